// File: doc/BRIEF.md
# Random-Number Register Front End

This block sits between an entropy or conditioning source and a processor bus. The source offers 32-bit words over a valid/ready handshake. The block gathers them into a four-word burst buffer. Software reaches the block through a small word-addressed register window with three registers: control, status and data. The status register shows whether a burst is ready, whether the source has reported a seed fault, and whether a clock fault was seen.

A ready burst is released all at once. After the status register reports data ready, software may read the data register four times in a row and gets a fresh word on each read. The buffer then refills only while generation is enabled and no seed fault is pending.

After a seed fault, the buffered words are thrown away. Software must then perform twelve data-register reads to flush the output path before the block delivers data again. It then checks the latched seed-fault flag to see whether the fault has come back.

Top module: `entropy_csr_front`

## Requirements
- R1: The control register sits at byte offset 0x00. Bit 2 enables generation and bit 5, when set, turns clock-fault detection off. All other bits read as zero, and the register resets to zero.
- R2: The status register sits at byte offset 0x04. Bit 0 is data ready, bit 2 is the current seed-fault state, bit 5 is the latched clock-fault flag and bit 6 is the latched seed-fault flag. It resets to zero.
- R3: While generation is enabled, no seed fault is pending and data ready is low, `src_ready` is high. When the fourth word is accepted, data ready (status bit 0) sets and `src_ready` falls.
- R4: Four consecutive reads of the data register (byte offset 0x08) return the four accepted words in arrival order. Data ready clears after the fourth read, and the buffer then refills.
- R5: A data-register read while data ready is low returns zero and consumes nothing. The next burst still comes out complete and in order.
- R6: Writing zero to the control register stops generation: `src_ready` stays low and offered words are not taken.
- R7: A one-cycle `seed_fault` pulse sets status bits 6 and 2, clears bit 0, and discards every buffered word.
- R8: While a seed fault is pending, data reads return zero. Bit 2 clears only at the twelfth such read, after which refill resumes. A new seed fault during the flush restarts the count at twelve and sets bit 6 again.
- R9: Writing 0 to bit 6 or bit 5 of the status register clears that latched flag, and writing zero to the whole register clears both. Writing 1 never sets a flag. A new fault in the same cycle as the clearing write wins.
- R10: While control bit 5 is zero, a high `clk_fault` sets status bit 5. While control bit 5 is one, `clk_fault` is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W (4) | Byte address; bits 1:0 are ignored |
| bus_wdata | input | DATA_W (32) | Write data |
| bus_rdata | output | DATA_W (32) | Read data for the addressed register, combinational |
| src_valid | input | 1 | Source word valid |
| src_data | input | DATA_W (32) | Source word |
| src_ready | output | 1 | Block takes the source word at this edge |
| seed_fault | input | 1 | Seed-fault pulse from the source |
| clk_fault | input | 1 | Clock-fault indication |

## Verification
A wrong drain or fill index shows up at the next data-register read as a word out of order, repeated or missing, which the scoreboard compares against its arrival queue. A data-ready flag set or cleared one burst early shows up in the status read right after the fourth accepted word or the fourth read. A wrong flush count is caught within one read of the twelfth, because status bit 2 is read back both after eleven reads and after twelve. A latched flag that takes writes of 1, or that misses a fault, shows in the first status read after the pulse or write.

// File: rtl/rng_csr_pkg.sv
`timescale 1ns/1ps
package rng_csr_pkg;

   // word index of each register inside the window (byte offset / 4)
   localparam int unsigned CTRL_WORD = 0;
   localparam int unsigned STAT_WORD = 1;
   localparam int unsigned DATA_WORD = 2;

   // control field positions
   localparam int unsigned CTRL_RUN_BIT    = 2;
   localparam int unsigned CTRL_CLKOFF_BIT = 5;

   // status field positions
   localparam int unsigned ST_READY_BIT    = 0;
   localparam int unsigned ST_SEEDNOW_BIT  = 2;
   localparam int unsigned ST_CLKFLAG_BIT  = 5;
   localparam int unsigned ST_SEEDFLAG_BIT = 6;

   typedef enum logic [1:0] {
      SEL_CTRL = 2'd0,
      SEL_STAT = 2'd1,
      SEL_DATA = 2'd2,
      SEL_NONE = 2'd3
   } reg_sel_e;

endpackage

// File: rtl/burst_store.sv
`timescale 1ns/1ps
module burst_store #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned DEPTH  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              fill_ok,
   input  logic              discard,
   input  logic              in_valid,
   input  logic [DATA_W-1:0] in_data,
   output logic              in_ready,
   input  logic              pop,
   output logic              burst_ready,
   output logic [DATA_W-1:0] head_data
);

   localparam int unsigned IDX_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(DEPTH - 1);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("burst_store: DEPTH must be a power of two of at least 2");
   end

   logic [IDX_W-1:0]  fill_idx;
   logic [IDX_W-1:0]  drain_idx;
   logic              full_q;
   logic [DATA_W-1:0] word_q [DEPTH];
   logic              take;

   assign in_ready = fill_ok && !full_q && !discard;
   assign take     = in_valid && in_ready;

   for (genvar g = 0; g < DEPTH; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            word_q[g] <= '0;
         end else if (take && fill_idx == IDX_W'(g)) begin
            word_q[g] <= in_data;
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fill_idx  <= '0;
         drain_idx <= '0;
         full_q    <= 1'b0;
      end else if (discard) begin
         fill_idx  <= '0;
         drain_idx <= '0;
         full_q    <= 1'b0;
      end else if (take) begin
         if (fill_idx == LAST_IDX) begin
            fill_idx  <= '0;
            drain_idx <= '0;
            full_q    <= 1'b1;
         end else begin
            fill_idx <= fill_idx + 1'b1;
         end
      end else if (pop && full_q) begin
         if (drain_idx == LAST_IDX) begin
            drain_idx <= '0;
            full_q    <= 1'b0;
         end else begin
            drain_idx <= drain_idx + 1'b1;
         end
      end
   end

   assign burst_ready = full_q;
   assign head_data   = full_q ? word_q[drain_idx] : '0;

endmodule

// File: rtl/seed_recovery.sv
`timescale 1ns/1ps
module seed_recovery #(
   parameter int unsigned FLUSH_READS = 12
) (
   input  logic clk,
   input  logic rst_n,
   input  logic seed_fault,
   input  logic data_rd,
   output logic fault_active
);

   localparam int unsigned CNT_W = $clog2(FLUSH_READS + 1);
   localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(FLUSH_READS);
   localparam logic [CNT_W-1:0] CNT_ONE  = CNT_W'(1);

   if (FLUSH_READS < 1) begin : g_bad_flush
      $error("seed_recovery: FLUSH_READS must be at least 1");
   end

   logic [CNT_W-1:0] left_q;
   logic             active_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         left_q   <= '0;
         active_q <= 1'b0;
      end else if (seed_fault) begin
         left_q   <= CNT_LOAD;
         active_q <= 1'b1;
      end else if (active_q && data_rd) begin
         if (left_q == CNT_ONE) begin
            left_q   <= '0;
            active_q <= 1'b0;
         end else begin
            left_q <= left_q - 1'b1;
         end
      end
   end

   assign fault_active = active_q;

endmodule

// File: rtl/fault_flags.sv
`timescale 1ns/1ps
module fault_flags (
   input  logic clk,
   input  logic rst_n,
   input  logic seed_fault,
   input  logic clk_fault,
   input  logic clk_chk_off,
   input  logic stat_wr,
   input  logic seed_keep,
   input  logic clk_keep,
   output logic seed_flag,
   output logic clk_flag
);

   logic seed_q;
   logic clk_q;
   logic clk_hit;

   assign clk_hit = clk_fault && !clk_chk_off;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         seed_q <= 1'b0;
         clk_q  <= 1'b0;
      end else begin
         if (seed_fault)
            seed_q <= 1'b1;
         else if (stat_wr && !seed_keep)
            seed_q <= 1'b0;

         if (clk_hit)
            clk_q <= 1'b1;
         else if (stat_wr && !clk_keep)
            clk_q <= 1'b0;
      end
   end

   assign seed_flag = seed_q;
   assign clk_flag  = clk_q;

endmodule

// File: rtl/entropy_csr_front.sv
`timescale 1ns/1ps
module entropy_csr_front
   import rng_csr_pkg::*;
#(
   parameter int unsigned DATA_W      = 32,
   parameter int unsigned ADDR_W      = 4,
   parameter int unsigned BURST_WORDS = 4,
   parameter int unsigned FLUSH_READS = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_we,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [DATA_W-1:0] bus_wdata,
   output logic [DATA_W-1:0] bus_rdata,
   input  logic              src_valid,
   input  logic [DATA_W-1:0] src_data,
   output logic              src_ready,
   input  logic              seed_fault,
   input  logic              clk_fault
);

   localparam int unsigned WIDX_W = ADDR_W - 2;

   if (DATA_W < 8) begin : g_bad_width
      $error("entropy_csr_front: DATA_W must hold the status field positions");
   end
   if (ADDR_W < 4) begin : g_bad_addr
      $error("entropy_csr_front: ADDR_W must cover three word registers");
   end

   logic [WIDX_W-1:0] word_idx;
   reg_sel_e          reg_sel;
   logic              gen_en_q;
   logic              clkchk_off_q;
   logic              ctrl_wr;
   logic              stat_wr;
   logic              data_rd;
   logic              buf_ready;
   logic              seed_now;
   logic              seed_flag;
   logic              clk_flag;
   logic [DATA_W-1:0] head_data;

   assign word_idx = bus_addr[ADDR_W-1:2];

   always_comb begin
      if (word_idx == WIDX_W'(CTRL_WORD))
         reg_sel = SEL_CTRL;
      else if (word_idx == WIDX_W'(STAT_WORD))
         reg_sel = SEL_STAT;
      else if (word_idx == WIDX_W'(DATA_WORD))
         reg_sel = SEL_DATA;
      else
         reg_sel = SEL_NONE;
   end

   assign ctrl_wr = bus_sel &&  bus_we && reg_sel == SEL_CTRL;
   assign stat_wr = bus_sel &&  bus_we && reg_sel == SEL_STAT;
   assign data_rd = bus_sel && !bus_we && reg_sel == SEL_DATA;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         gen_en_q     <= 1'b0;
         clkchk_off_q <= 1'b0;
      end else if (ctrl_wr) begin
         gen_en_q     <= bus_wdata[CTRL_RUN_BIT];
         clkchk_off_q <= bus_wdata[CTRL_CLKOFF_BIT];
      end
   end

   burst_store #(
      .DATA_W (DATA_W),
      .DEPTH  (BURST_WORDS)
   ) u_store (
      .clk         (clk),
      .rst_n       (rst_n),
      .fill_ok     (gen_en_q && !seed_now),
      .discard     (seed_fault),
      .in_valid    (src_valid),
      .in_data     (src_data),
      .in_ready    (src_ready),
      .pop         (data_rd),
      .burst_ready (buf_ready),
      .head_data   (head_data)
   );

   seed_recovery #(
      .FLUSH_READS (FLUSH_READS)
   ) u_recover (
      .clk          (clk),
      .rst_n        (rst_n),
      .seed_fault   (seed_fault),
      .data_rd      (data_rd),
      .fault_active (seed_now)
   );

   fault_flags u_flags (
      .clk         (clk),
      .rst_n       (rst_n),
      .seed_fault  (seed_fault),
      .clk_fault   (clk_fault),
      .clk_chk_off (clkchk_off_q),
      .stat_wr     (stat_wr),
      .seed_keep   (bus_wdata[ST_SEEDFLAG_BIT]),
      .clk_keep    (bus_wdata[ST_CLKFLAG_BIT]),
      .seed_flag   (seed_flag),
      .clk_flag    (clk_flag)
   );

   always_comb begin
      bus_rdata = '0;
      case (reg_sel)
         SEL_CTRL: begin
            bus_rdata[CTRL_RUN_BIT]    = gen_en_q;
            bus_rdata[CTRL_CLKOFF_BIT] = clkchk_off_q;
         end
         SEL_STAT: begin
            bus_rdata[ST_READY_BIT]    = buf_ready;
            bus_rdata[ST_SEEDNOW_BIT]  = seed_now;
            bus_rdata[ST_CLKFLAG_BIT]  = clk_flag;
            bus_rdata[ST_SEEDFLAG_BIT] = seed_flag;
         end
         SEL_DATA: bus_rdata = head_data;
         default:  bus_rdata = '0;
      endcase
   end

   logic unused_bits;
   assign unused_bits = ^{bus_addr[1:0], bus_wdata[DATA_W-1:7],
                          bus_wdata[4:3], bus_wdata[1:0]};

endmodule

// File: rtl/entropy_csr_front_chk.sv
`timescale 1ns/1ps
module entropy_csr_front_chk #(
   parameter int unsigned DATA_W = 32
) (
   input logic              clk,
   input logic              rst_n,
   input logic              seed_fault,
   input logic              clk_fault,
   input logic              clk_chk_off,
   input logic              src_ready,
   input logic              drdy,
   input logic              seed_now,
   input logic              seed_flag,
   input logic              clk_flag,
   input logic              data_rd,
   input logic [DATA_W-1:0] bus_rdata
);

   // R3
   full_blocks_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drdy |-> !src_ready);

   // R5
   empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (data_rd && !drdy) |-> bus_rdata == '0);

   // R7
   seed_fault_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seed_fault |=> (seed_flag && seed_now && !drdy));

   // R8
   recovery_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seed_now |-> !drdy);

   // R9
   seed_flag_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(seed_flag) |-> $past(seed_fault));

   // R10
   clk_flag_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!clk_flag && (!clk_fault || clk_chk_off)) |=> !clk_flag);

endmodule

bind entropy_csr_front entropy_csr_front_chk #(.DATA_W(DATA_W)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .seed_fault  (seed_fault),
   .clk_fault   (clk_fault),
   .clk_chk_off (clkchk_off_q),
   .src_ready   (src_ready),
   .drdy        (buf_ready),
   .seed_now    (seed_now),
   .seed_flag   (seed_flag),
   .clk_flag    (clk_flag),
   .data_rd     (data_rd),
   .bus_rdata   (bus_rdata)
);

// File: tb/entropy_csr_front_test.sv
`timescale 1ns/1ps
module entropy_csr_front_test;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        bus_sel = 1'b0;
   logic        bus_we = 1'b0;
   logic [3:0]  bus_addr = '0;
   logic [31:0] bus_wdata = '0;
   logic [31:0] bus_rdata;
   logic        src_valid = 1'b0;
   logic [31:0] src_data = '0;
   logic        src_ready;
   logic        seed_fault = 1'b0;
   logic        clk_fault = 1'b0;

   int checks = 0;
   int failures = 0;
   logic mon_on = 1'b0;
   logic [31:0] exp_q [$];
   logic [31:0] rv;

   always #2.5 clk = ~clk;

   entropy_csr_front uut (
      .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .src_valid(src_valid), .src_data(src_data), .src_ready(src_ready),
      .seed_fault(seed_fault), .clk_fault(clk_fault)
   );

   task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         failures++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // scoreboard monitor: every data read with mon_on pops one expected word (R4)
   always @(posedge clk) begin
      if (mon_on && bus_sel && !bus_we && bus_addr == 4'h8) begin
         checks++;
         if (exp_q.size() == 0) begin
            failures++;
            $display("FAIL R4 actual=%h expected=<queue empty>", bus_rdata);
         end else begin
            logic [31:0] e;
            e = exp_q.pop_front();
            if (bus_rdata !== e) begin
               failures++;
               $display("FAIL R4 actual=%h expected=%h", bus_rdata, e);
            end
         end
      end
   end

   task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_we = 1'b0;
   endtask

   task automatic bus_rd(input logic [3:0] a, output logic [31:0] d);
      @(negedge clk);
      bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
      #1 d = bus_rdata;
      @(negedge clk);
      bus_sel = 1'b0;
   endtask

   task automatic send_word(input logic [31:0] w);
      @(negedge clk);
      src_valid = 1'b1; src_data = w;
      #1;
      while (!src_ready) begin
         @(negedge clk);
         #1;
      end
      @(posedge clk);
      exp_q.push_back(w);
   endtask

   task automatic src_idle();
      @(negedge clk);
      src_valid = 1'b0;
   endtask

   task automatic send_burst(input logic [31:0] base);
      for (int i = 0; i < 4; i++) send_word(base + 32'(i) * 32'h0101_0101);
      src_idle();
   endtask

   task automatic drain_burst();
      mon_on = 1'b1;
      for (int i = 0; i < 4; i++) bus_rd(4'h8, rv);
      mon_on = 1'b0;
   endtask

   task automatic pulse_seed();
      @(negedge clk); seed_fault = 1'b1;
      @(negedge clk); seed_fault = 1'b0;
   endtask

   task automatic pulse_clk();
      @(negedge clk); clk_fault = 1'b1;
      @(negedge clk); clk_fault = 1'b0;
   endtask

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      failures++;
      $display("FAIL watchdog actual=running expected=finished");
      summary();
      $finish;
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // reset state
      bus_rd(4'h0, rv); check("R1 ctrl reset", rv, 32'h0);
      bus_rd(4'h4, rv); check("R2 status reset", rv, 32'h0);
      #1 check("R6 src_ready low while stopped", {31'b0, src_ready}, 32'h0);

      // control field layout
      bus_wr(4'h0, 32'h0000_0024);
      bus_rd(4'h0, rv); check("R1 ctrl readback", rv, 32'h24);
      bus_wr(4'h0, 32'hFFFF_FFFF);
      bus_rd(4'h0, rv); check("R1 ctrl unused bits", rv, 32'h24);
      bus_wr(4'h0, 32'h0000_0004);
      #1 check("R3 src_ready when enabled", {31'b0, src_ready}, 32'h1);

      // first burst
      send_burst(32'hA500_0011);
      bus_rd(4'h4, rv); check("R3 data ready after four words", rv, 32'h1);
      #1 check("R3 src_ready low while ready", {31'b0, src_ready}, 32'h0);
      drain_burst();
      bus_rd(4'h4, rv); check("R4 ready cleared after burst", rv, 32'h0);

      // empty read
      bus_rd(4'h8, rv); check("R5 empty read zero", rv, 32'h0);
      bus_rd(4'h4, rv); check("R5 status after empty read", rv, 32'h0);
      send_burst(32'h1234_5678);
      drain_burst();

      // stop generation mid-burst
      send_word(32'hC0DE_0001);
      send_word(32'hC0DE_0002);
      src_idle();
      bus_wr(4'h0, 32'h0);
      #1 check("R6 src_ready after stop", {31'b0, src_ready}, 32'h0);
      @(negedge clk); src_valid = 1'b1; src_data = 32'hDEAD_BEEF;
      repeat (3) @(negedge clk);
      src_valid = 1'b0;
      bus_rd(4'h4, rv); check("R6 nothing taken while stopped", rv, 32'h0);
      bus_wr(4'h0, 32'h4);
      send_word(32'hC0DE_0003);
      send_word(32'hC0DE_0004);
      src_idle();
      bus_rd(4'h4, rv); check("R4 ready after resumed fill", rv, 32'h1);
      drain_burst();

      // seed fault with full buffer
      send_burst(32'h5EED_0000);
      pulse_seed();
      exp_q.delete();
      bus_rd(4'h4, rv); check("R7 status after seed fault", rv, 32'h44);
      #1 check("R7 src_ready during fault", {31'b0, src_ready}, 32'h0);
      bus_wr(4'h4, 32'hFFFF_FFBF);
      bus_rd(4'h4, rv); check("R9 seed flag cleared by zero", rv, 32'h4);
      for (int i = 0; i < 11; i++) begin
         bus_rd(4'h8, rv); check("R8 flush read zero", rv, 32'h0);
      end
      bus_rd(4'h4, rv); check("R8 still pending after eleven", rv, 32'h4);
      bus_rd(4'h8, rv); check("R8 twelfth flush read zero", rv, 32'h0);
      bus_rd(4'h4, rv); check("R8 cleared after twelve", rv, 32'h0);
      #1 check("R8 refill resumes", {31'b0, src_ready}, 32'h1);

      // fault repeated during flush restarts the count
      pulse_seed();
      for (int i = 0; i < 5; i++) bus_rd(4'h8, rv);
      pulse_seed();
      for (int i = 0; i < 11; i++) bus_rd(4'h8, rv);
      bus_rd(4'h4, rv); check("R8 restart keeps fault pending", rv, 32'h44);
      bus_rd(4'h8, rv);
      bus_rd(4'h4, rv); check("R8 restart clears at twelve", rv, 32'h40);
      bus_wr(4'h4, 32'h0);
      bus_rd(4'h4, rv); check("R9 zero write clears all", rv, 32'h0);
      send_burst(32'h0BAD_F00D);
      drain_burst();

      // clock fault flag
      pulse_clk();
      bus_rd(4'h4, rv); check("R10 clock fault latched", rv, 32'h20);
      bus_wr(4'h4, 32'hFFFF_FFFF);
      bus_rd(4'h4, rv); check("R9 ones keep flag", rv, 32'h20);
      bus_wr(4'h4, 32'hFFFF_FFDF);
      bus_rd(4'h4, rv); check("R9 clock flag cleared by zero", rv, 32'h0);
      bus_wr(4'h0, 32'h24);
      pulse_clk();
      bus_rd(4'h4, rv); check("R10 ignored when detection off", rv, 32'h0);
      bus_wr(4'h4, 32'hFFFF_FFFF);
      bus_rd(4'h4, rv); check("R9 ones cannot set flags", rv, 32'h0);

      check("R4 scoreboard empty", 32'(exp_q.size()), 32'h0);
      summary();
      $finish;
   end

endmodule